// File: doc/BRIEF.md
# Banked Local Memory Conflict Serializer

This block sits in front of a 32-bank local scratch memory and turns one wide vector access into a sequence of conflict-free bank passes. A request carries up to 64 lane byte addresses plus an active mask. The bank a lane uses comes from the dword-granular low address bits, and the row inside that bank comes from every bit above them. Lanes on the same bank that name the same dword are served together as a broadcast. Lanes on the same bank that name different rows must take separate passes.

Once a request is accepted, the block emits one pass every clock. A pass gives a per-bank enable and row, plus the set of lanes served in that pass. Within each bank, the lowest-numbered lane still pending wins, and every pending lane with the same dword address rides along with it. A done flag marks the final pass. A running pass count, which holds its final value after completion, tells the issue logic how many cycles the access cost.

Top module: `lds_bank_serializer`

## Requirements
- R1: A lane's bank is address bits [6:2] (bank = (addr >> 2) mod 32). Lanes on different banks never delay each other, and all of them are served in the same pass.
- R2: Address bits [1:0] take no part in bank selection or conflict checks. Lanes whose addresses differ only in those bits are served in the same pass.
- R3: A lane's row is address bits [ADDR_W-1:7]. Two pending lanes on the same bank with different rows are served in different passes. `bank_addr_o[b*ROW_W +: ROW_W]` carries the row granted to bank b, and is zero when `bank_en_o[b]` is low.
- R4: All pending lanes that share a bank and a row are served in one pass as a broadcast.
- R5: In each pass, each bank grants the row of its lowest-numbered pending lane.
- R6: Lanes whose mask bit is 0 never appear in `lanes_o`, never enable a bank and never add a pass.
- R7: A request with an all-zero mask completes in the first cycle after acceptance. In that cycle `done_o` is 1, `pass_valid_o` is 0 and `pass_cnt_o` is 0.
- R8: `req_ready_o` is 1 exactly when no request is in progress, and a request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1.
  - The first pass appears in the cycle after acceptance, and one pass follows per cycle after that.
  - While ready is 1, no bank is enabled and `pass_valid_o` is 0.
- R9: `done_o` is 1 in the pass that serves the last pending lane.
  - During a pass, `pass_cnt_o` equals the number of passes so far, including the current one.
  - After completion, `pass_cnt_o` holds the request's total until the next acceptance.
- R10: When all 64 lanes are active on one bank with 64 distinct rows, the request takes exactly 64 passes. No request takes more passes than it has active lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Serializer idle, request can be taken |
| req_addr_i | input | LANES*ADDR_W | Lane byte addresses, lane l at [l*ADDR_W +: ADDR_W] |
| req_mask_i | input | LANES | Lane active mask |
| pass_valid_o | output | 1 | A pass with at least one served lane is presented |
| bank_en_o | output | BANKS | Bank used in this pass |
| bank_addr_o | output | BANKS*ROW_W | Granted row per bank |
| lanes_o | output | LANES | Lanes served in this pass |
| done_o | output | 1 | Final cycle of the current request |
| pass_cnt_o | output | CNT_W | Passes so far, including the current one |

## Verification
The bench targets several corner cases, each of which exposes a specific fault:
- Lanes that differ only in their byte offset. A design that keeps bits [1:0] in the comparison would split them into two passes.
- A full broadcast to a single dword. A design without merging would take 64 passes instead of one.
- Reversed row order on one bank. A design that grants from the wrong end would serve lane 63 first.
- A 64-way conflict, which catches counters or pending registers that wrap.
- An all-zero mask. A faulty design would either hang or report a phantom pass.
- Masks with conflicting inactive lanes. A faulty design would serve those lanes or add passes for them.

Random masks over a small address window mix merges and conflicts. They are compared cycle by cycle against a lane-ordered reference model.

// File: rtl/lds_ser_pkg.sv
package lds_ser_pkg;
  localparam int unsigned BANK_LSB = 2;
  typedef enum logic {ST_IDLE, ST_BUSY} ser_state_e;
endpackage

// File: rtl/lds_bank_pick.sv
module lds_bank_pick #(
  parameter int unsigned LANES   = 64,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BANK_W  = 5,
  parameter int unsigned BANK_ID = 0,
  localparam int unsigned ROW_LSB = lds_ser_pkg::BANK_LSB + BANK_W,
  localparam int unsigned ROW_W   = ADDR_W - ROW_LSB,
  localparam int unsigned LANE_W  = $clog2(LANES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LANES-1:0]         pend_i,
  input  logic [LANES*ADDR_W-1:0]  addr_i,
  output logic                     en_o,
  output logic [ROW_W-1:0]         row_o,
  output logic [LANES-1:0]         served_o
);
  import lds_ser_pkg::*;

  logic [ROW_W-1:0]  row [LANES];
  logic [LANES-1:0]  hit;
  logic [LANE_W-1:0] sel;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign row[l] = addr_i[l*ADDR_W+ROW_LSB +: ROW_W];
    assign hit[l] = pend_i[l] &&
                    (addr_i[l*ADDR_W+BANK_LSB +: BANK_W] == BANK_W'(BANK_ID));
  end

  // lowest pending lane on this bank wins
  always_comb begin
    sel = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (hit[l]) sel = LANE_W'(l);
    end
  end

  assign en_o  = |hit;
  assign row_o = en_o ? row[sel] : '0;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      served_o[l] = hit[l] && (row[l] == row[sel]);
    end
  end

  p_grant_iff_served_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o == (served_o != '0));
  p_lowest_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit & (~hit + 1'b1)) & ~served_o) == '0);
  p_served_on_bank_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (served_o & ~hit) == '0);
endmodule

// File: rtl/lds_ser_ctrl.sv
module lds_ser_ctrl #(
  parameter int unsigned LANES = 64,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LANES-1:0] req_mask_i,
  input  logic [LANES-1:0] served_i,
  output logic             req_ready_o,
  output logic             accept_o,
  output logic [LANES-1:0] pend_o,
  output logic             pass_valid_o,
  output logic             done_o,
  output logic [CNT_W-1:0] pass_cnt_o
);
  import lds_ser_pkg::*;

  ser_state_e       state_q;
  logic [LANES-1:0] pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy;
  logic [LANES-1:0] remain;

  assign busy         = (state_q == ST_BUSY);
  assign req_ready_o  = !busy;
  assign accept_o     = req_valid_i && !busy;
  assign remain       = pend_q & ~served_i;
  assign pass_valid_o = busy && (pend_q != '0);
  assign done_o       = busy && (remain == '0);
  assign pass_cnt_o   = cnt_q + CNT_W'(pass_valid_o);
  assign pend_o       = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      cnt_q   <= '0;
    end else if (accept_o) begin
      state_q <= ST_BUSY;
      pend_q  <= req_mask_i;
      cnt_q   <= '0;
    end else if (busy) begin
      pend_q  <= remain;
      cnt_q   <= pass_cnt_o;
      if (done_o) state_q <= ST_IDLE;
    end
  end

  p_progress_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_valid_o |-> (served_i & pend_q) != '0);
  p_no_reserve_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (served_i & ~pend_q) == '0);
  p_done_to_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o);
  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_valid_o && !done_o) |=> (pass_cnt_o == $past(pass_cnt_o) + 1'b1));
  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LANES));
endmodule

// File: rtl/lds_bank_serializer.sv
module lds_bank_serializer #(
  parameter int unsigned LANES  = 64,
  parameter int unsigned BANKS  = 32,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned ROW_W  = ADDR_W - lds_ser_pkg::BANK_LSB - BANK_W,
  localparam int unsigned CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]        req_mask_i,
  output logic                    pass_valid_o,
  output logic [BANKS-1:0]        bank_en_o,
  output logic [BANKS*ROW_W-1:0]  bank_addr_o,
  output logic [LANES-1:0]        lanes_o,
  output logic                    done_o,
  output logic [CNT_W-1:0]        pass_cnt_o
);
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        pend;
  logic                    accept;
  logic [LANES-1:0]        served_b [BANKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= req_addr_i;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    lds_bank_pick #(
      .LANES(LANES), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_ID(b)
    ) u_pick (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pend_i   (pend),
      .addr_i   (addr_q),
      .en_o     (bank_en_o[b]),
      .row_o    (bank_addr_o[b*ROW_W +: ROW_W]),
      .served_o (served_b[b])
    );
  end

  always_comb begin
    lanes_o = '0;
    for (int b = 0; b < BANKS; b++) lanes_o |= served_b[b];
  end

  lds_ser_ctrl #(.LANES(LANES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_mask_i   (req_mask_i),
    .served_i     (lanes_o),
    .req_ready_o  (req_ready_o),
    .accept_o     (accept),
    .pend_o       (pend),
    .pass_valid_o (pass_valid_o),
    .done_o       (done_o),
    .pass_cnt_o   (pass_cnt_o)
  );

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!pass_valid_o && bank_en_o == '0 && lanes_o == '0));
  p_lanes_vs_banks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bank_en_o) <= $countones(lanes_o));
endmodule

// File: tb/lds_bank_serializer_test.sv
module lds_bank_serializer_test;
  localparam int LANES = 64;
  localparam int BANKS = 32;
  localparam int AW    = 16;
  localparam int ROW_W = AW - 7;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES-1:0] req_mask = '0;
  logic pass_valid, done;
  logic [BANKS-1:0] bank_en;
  logic [BANKS*ROW_W-1:0] bank_addr;
  logic [LANES-1:0] lanes;
  logic [CNT_W-1:0] pass_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  logic [AW-1:0] ta [LANES];
  logic [LANES-1:0] tmask;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  lds_bank_serializer #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_mask_i(req_mask), .pass_valid_o(pass_valid),
    .bank_en_o(bank_en), .bank_addr_o(bank_addr), .lanes_o(lanes),
    .done_o(done), .pass_cnt_o(pass_cnt)
  );

  task automatic chk(input string tag, input bit [511:0] act, input bit [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference: walk lanes in ascending order; first pending lane claims its bank's row.
  task automatic run_req(input string tag, input int exp_passes);
    logic [LANES-1:0] pend;
    logic [LANES-1:0] srv;
    logic [BANKS-1:0] claimed;
    logic [ROW_W-1:0] crow [BANKS];
    logic [BANKS*ROW_W-1:0] eaddr;
    int n;
    @(negedge clk);
    chk({tag, " R8 ready before request"}, 512'(req_ready), 512'(1));
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = ta[l];
    req_mask  = tmask;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    pend = tmask;
    n = 0;
    for (int it = 0; it < 80; it++) begin
      srv = '0;
      claimed = '0;
      eaddr = '0;
      for (int b = 0; b < BANKS; b++) crow[b] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (pend[l]) begin
          int b = int'(ta[l][6:2]);
          if (!claimed[b]) begin
            claimed[b] = 1'b1;
            crow[b] = ta[l][AW-1:7];
            srv[l] = 1'b1;
          end else if (crow[b] == ta[l][AW-1:7]) begin
            srv[l] = 1'b1;
          end
        end
      end
      for (int b = 0; b < BANKS; b++) eaddr[b*ROW_W +: ROW_W] = crow[b];
      if (pend != '0) n++;
      chk({tag, " R8 busy not ready"}, 512'(req_ready), 512'(0));
      chk({tag, " R9 pass_valid"}, 512'(pass_valid), 512'(pend != '0));
      chk({tag, " R5 lanes served"}, 512'(lanes), 512'(srv));
      chk({tag, " R1 bank enables"}, 512'(bank_en), 512'(claimed));
      chk({tag, " R3 bank rows"}, 512'(bank_addr), 512'(eaddr));
      chk({tag, " R9 done"}, 512'(done), 512'((pend & ~srv) == '0));
      chk({tag, " R9 pass count"}, 512'(pass_cnt), 512'(n));
      chk({tag, " R6 inactive lanes"}, 512'(lanes & ~tmask), 512'(0));
      pend = pend & ~srv;
      if (pend == '0) break;
      @(negedge clk);
    end
    if (exp_passes >= 0) chk({tag, " total passes"}, 512'(n), 512'(exp_passes));
    @(negedge clk);
    chk({tag, " R8 ready after done"}, 512'(req_ready), 512'(1));
    chk({tag, " R9 count held"}, 512'(pass_cnt), 512'(n));
    chk({tag, " R8 idle quiet"}, 512'({pass_valid, bank_en, done}), 512'(0));
  endtask

  initial begin
    wait (cycles == 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset ready", 512'(req_ready), 512'(1));
    chk("R9 reset outputs", 512'({pass_valid, done, bank_en, lanes, pass_cnt}), 512'(0));
    rst_n = 1'b1;

    // R1/R3: lanes 0-31 row 0, lanes 32-63 row 1, one lane per bank per row
    for (int l = 0; l < LANES; l++) ta[l] = AW'(l * 4);
    tmask = '1;
    run_req("R1 R3 stride", 2);

    // R2: lanes l and l+32 share bank and row, differ in bits [1:0]
    for (int l = 0; l < LANES; l++) ta[l] = AW'((l % 32) * 4 + (l / 32) * 3 + 256);
    run_req("R2 byte offset", 1);

    // R4: full broadcast
    for (int l = 0; l < LANES; l++) ta[l] = 16'h0100;
    run_req("R4 broadcast", 1);

    // R10: 64-way conflict on bank 0
    for (int l = 0; l < LANES; l++) ta[l] = AW'(l * 128);
    run_req("R10 worst", 64);

    // R5: reversed rows, lane 0 must be granted first
    for (int l = 0; l < LANES; l++) ta[l] = AW'((63 - l) * 128 + 8);
    run_req("R5 reversed", 64);

    // R6: odd lanes inactive but conflicting
    for (int l = 0; l < LANES; l++) ta[l] = AW'(l * 128);
    tmask = {32{2'b01}};
    run_req("R6 masked", 32);

    // R7: empty request
    tmask = '0;
    run_req("R7 empty", 0);

    // R10 single active lane
    tmask = 64'h8000_0000_0000_0000;
    run_req("R10 single", 1);

    for (int k = 0; k < 12; k++) begin
      for (int l = 0; l < LANES; l++) ta[l] = AW'($urandom_range(0, (k < 6) ? 511 : 4095));
      tmask = {$urandom, $urandom};
      run_req("R3 R4 random", -1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule